// File: doc/BRIEF.md
# Dual-Mode Processor Bus Register Slave

This block connects an external processor bus to an on-chip register file. It turns the processor's bus cycles into single-cycle internal read and write strobes, which come with a registered address and write data. It then returns the read data together with an acknowledge. One static input selects the protocol. In clocked mode the processor marks each access with a one-cycle address strobe, and the chip select is sampled on the same rising edge. In strobe-only mode the address strobe stays low for the whole cycle, and a data strobe tells the block when the access may be committed.

Both protocols are sampled by the processor clock. In strobe-only mode the chip select, address strobe and data strobe each pass through a synchronizer. The falling edge of the synchronized data strobe is then confirmed for one more cycle before any register is touched. If the strobe drops away before that confirmation, the access is abandoned with no side effect.

Top module: `mpbus_slave`

## Requirements
- R1: `sync_mode`=1 selects the clocked protocol and `sync_mode`=0 selects the strobe-only protocol. In strobe-only mode, a one-cycle address strobe pulse with chip select low and no data strobe produces no internal access.
- R2: In clocked mode, a rising edge that samples `bus_as_n`=0 and `bus_cs_n`=0 while idle starts an access. The strobe (`reg_rd` or `reg_wr`) is high for exactly the one cycle after that edge. An address strobe with `bus_cs_n`=1 starts nothing.
- R3: The address is taken from `bus_addr` while `bus_as_n` is low. It stays on `reg_addr` after the strobe rises, even if `bus_addr` changes.
- R4: `bus_rw`=1 gives a read (`reg_rd`). `bus_rw`=0 gives a write (`reg_wr`), and `reg_wdata` carries the bus write data during the strobe.
- R5: In clocked mode `bus_ds_n` has no effect. Toggling it produces no access, and an access made while it is held low behaves like one made while it is high.
- R6: In strobe-only mode, with chip select and address strobe low, the strobe appears in the fourth cycle after the edge that first samples `bus_ds_n` low. Only one access occurs for each low period of `bus_ds_n`, however long that period lasts.
- R7: In strobe-only mode, a falling `bus_ds_n` while `bus_cs_n` is high starts no access.
- R8: `bus_ack` rises one clock after the strobe. On a read, `bus_rdata` equals the `reg_rdata` value present during the strobe. On a write, `bus_rdata` is 0.
- R9: In clocked mode `bus_ack` stays high for exactly two cycles. After that, `bus_ack` and `bus_rdata` return to 0.
- R10: In strobe-only mode `bus_ack` stays high until `bus_ds_n` rises. It falls on the third edge after that rise.
- R11: If the synchronized data strobe goes high before the strobe is issued, the access is aborted: no `reg_rd` or `reg_wr` occurs. The next access then completes normally.
- R12: After reset, `bus_ack`, `bus_rdata`, `reg_rd` and `reg_wr` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 1 = clocked protocol, 0 = strobe-only protocol (static) |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_as_n | input | 1 | Address strobe, active low |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_ds_n | input | 1 | Data strobe, active low, used only in strobe-only mode |
| bus_addr | input | AW | Bus address |
| bus_wdata | input | DW | Bus write data |
| bus_rdata | output | DW | Read data returned to the bus |
| bus_ack | output | 1 | Transfer acknowledge |
| reg_rd | output | 1 | One-cycle internal read strobe |
| reg_wr | output | 1 | One-cycle internal write strobe |
| reg_addr | output | AW | Latched register address |
| reg_wdata | output | DW | Registered write data |
| reg_rdata | input | DW | Read data from the register file |

## Verification
In clocked mode the strobe is due one cycle after the sampling edge. The acknowledge follows in the next two cycles and is gone in the fourth. In strobe-only mode the strobe is due four cycles after the data strobe is first sampled low, and the acknowledge is due one cycle later. After the data strobe rises, the acknowledge holds for two more samples and is gone on the third. The bench drives every input on the falling clock edge and counts falling edges from each stimulus to exactly these cycles before it samples. A strobe monitor counts the accesses, which shows that aborted, deselected and ignored cycles left no access behind.

// File: rtl/mpbus_pkg.sv
package mpbus_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_QUAL  = 2'd1,
      ST_ISSUE = 2'd2,
      ST_HOLD  = 2'd3
   } mpbus_state_t;
endpackage

// File: rtl/mpbus_sync.sv
module mpbus_sync #(
   parameter int WIDTH = 3,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] q_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mpbus_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[0] <= RST_VAL;
            else        stg_q[0] <= d_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= RST_VAL;
            else        stg_q[i] <= stg_q[i-1];
         end
      end
   end

   assign q_out = stg_q[STAGES-1];
endmodule

// File: rtl/mpbus_fall_det.sv
module mpbus_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_n,
   output logic fall
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sig_n;
   end

   assign fall = prev_q & ~sig_n;
endmodule

// File: rtl/mpbus_addr_latch.sv
module mpbus_addr_latch #(
   parameter int AW = 21
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          capture,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (capture) addr_q <= addr_in;
   end
endmodule

// File: rtl/mpbus_ctrl.sv
module mpbus_ctrl
   import mpbus_pkg::*;
#(
   parameter int DW = 32,
   parameter int ACK_CYCLES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_mode,
   input  logic          bus_cs_n,
   input  logic          bus_as_n,
   input  logic          bus_rw,
   input  logic [DW-1:0] bus_wdata,
   input  logic          cs_s,
   input  logic          as_s,
   input  logic          ds_s,
   input  logic          ds_fall,
   input  logic [DW-1:0] reg_rdata,
   output logic          reg_wr,
   output logic          reg_rd,
   output logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          bus_ack,
   output logic          idle
);
   localparam int CW = $clog2(ACK_CYCLES + 1);
   localparam logic [CW-1:0] LAST = CW'(ACK_CYCLES - 1);

   mpbus_state_t  state_q;
   logic          rw_q;
   logic [DW-1:0] wdata_q;
   logic [DW-1:0] rdata_q;
   logic          ack_q;
   logic [CW-1:0] cnt_q;
   logic          async_go;

   // confirmation: all synchronized strobes still asserted
   assign async_go = ~ds_s & ~cs_s & ~as_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         rw_q    <= 1'b1;
         wdata_q <= '0;
         rdata_q <= '0;
         ack_q   <= 1'b0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (sync_mode) begin
                  if (!bus_as_n && !bus_cs_n) begin
                     state_q <= ST_ISSUE;
                     rw_q    <= bus_rw;
                     wdata_q <= bus_wdata;
                  end
               end else if (ds_fall && !cs_s && !as_s) begin
                  state_q <= ST_QUAL;
               end
            end
            ST_QUAL: begin
               if (async_go) begin
                  state_q <= ST_ISSUE;
                  rw_q    <= bus_rw;
                  wdata_q <= bus_wdata;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            ST_ISSUE: begin
               state_q <= ST_HOLD;
               ack_q   <= 1'b1;
               rdata_q <= rw_q ? reg_rdata : '0;
               cnt_q   <= '0;
            end
            ST_HOLD: begin
               if (sync_mode) begin
                  if (cnt_q == LAST) begin
                     state_q <= ST_IDLE;
                     ack_q   <= 1'b0;
                     rdata_q <= '0;
                  end else begin
                     cnt_q <= cnt_q + 1'b1;
                  end
               end else if (ds_s) begin
                  state_q <= ST_IDLE;
                  ack_q   <= 1'b0;
                  rdata_q <= '0;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign reg_wr    = (state_q == ST_ISSUE) & ~rw_q;
   assign reg_rd    = (state_q == ST_ISSUE) &  rw_q;
   assign reg_wdata = wdata_q;
   assign bus_rdata = rdata_q;
   assign bus_ack   = ack_q;
   assign idle      = (state_q == ST_IDLE);
endmodule

// File: rtl/mpbus_slave.sv
module mpbus_slave #(
   parameter int AW = 21,
   parameter int DW = 32,
   parameter int SYNC_STAGES = 2,
   parameter int ACK_CYCLES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sync_mode,
   input  logic          bus_cs_n,
   input  logic          bus_as_n,
   input  logic          bus_rw,
   input  logic          bus_ds_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic          bus_ack,
   output logic          reg_rd,
   output logic          reg_wr,
   output logic [AW-1:0] reg_addr,
   output logic [DW-1:0] reg_wdata,
   input  logic [DW-1:0] reg_rdata
);
   localparam int NSIG = 3;

   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("mpbus_slave: AW and DW must be positive");
   end
   if (ACK_CYCLES < 1) begin : g_bad_ack
      $error("mpbus_slave: ACK_CYCLES must be at least 1");
   end

   logic [NSIG-1:0] strb_s;
   logic            cs_s, as_s, ds_s, ds_fall, idle, addr_cap;

   mpbus_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES), .RST_VAL('1)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  ({bus_cs_n, bus_as_n, bus_ds_n}),
      .q_out (strb_s)
   );
   assign {cs_s, as_s, ds_s} = strb_s;

   mpbus_fall_det ds_edge_i (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_n (ds_s),
      .fall  (ds_fall)
   );

   // clocked mode takes the address only on a starting edge
   assign addr_cap = ~bus_as_n & (sync_mode ? (idle & ~bus_cs_n) : 1'b1);

   mpbus_addr_latch #(.AW(AW)) addr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (addr_cap),
      .addr_in (bus_addr),
      .addr_q  (reg_addr)
   );

   mpbus_ctrl #(.DW(DW), .ACK_CYCLES(ACK_CYCLES)) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_mode (sync_mode),
      .bus_cs_n  (bus_cs_n),
      .bus_as_n  (bus_as_n),
      .bus_rw    (bus_rw),
      .bus_wdata (bus_wdata),
      .cs_s      (cs_s),
      .as_s      (as_s),
      .ds_s      (ds_s),
      .ds_fall   (ds_fall),
      .reg_rdata (reg_rdata),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_wdata (reg_wdata),
      .bus_rdata (bus_rdata),
      .bus_ack   (bus_ack),
      .idle      (idle)
   );
endmodule

// File: rtl/mpbus_slave_chk.sv
module mpbus_slave_chk #(
   parameter int DW = 32,
   parameter int ACK_CYCLES = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sync_mode,
   input logic          bus_cs_n,
   input logic          bus_as_n,
   input logic          reg_wr,
   input logic          reg_rd,
   input logic [DW-1:0] reg_rdata,
   input logic [DW-1:0] bus_rdata,
   input logic          bus_ack
);
   localparam int RW = $clog2(ACK_CYCLES + 2);
   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_q <= '0;
      else if (bus_ack) run_q <= run_q + 1'b1;
      else              run_q <= '0;
   end

   // R2
   sync_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && !bus_as_n && !bus_cs_n && !bus_ack && !reg_wr && !reg_rd)
      |=> (reg_wr || reg_rd));

   // R2
   strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr || reg_rd) |=> !(reg_wr || reg_rd));

   // R8
   ack_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |=> (bus_ack && bus_rdata == $past(reg_rdata)));

   // R8
   ack_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> (bus_ack && bus_rdata == '0));

   // R9
   sync_ack_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_mode && $fell(bus_ack)) |-> (run_q == RW'(ACK_CYCLES)));
endmodule

bind mpbus_slave mpbus_slave_chk #(.DW(DW), .ACK_CYCLES(ACK_CYCLES)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .sync_mode (sync_mode),
   .bus_cs_n  (bus_cs_n),
   .bus_as_n  (bus_as_n),
   .reg_wr    (reg_wr),
   .reg_rd    (reg_rd),
   .reg_rdata (reg_rdata),
   .bus_rdata (bus_rdata),
   .bus_ack   (bus_ack)
);

// File: tb/mpbus_slave_tb.sv
`timescale 1ns/1ps
module mpbus_slave_tb_top;
   localparam int AW = 21;
   localparam int DW = 32;
   localparam int NV = 6;
   localparam int VW = 2 + AW + DW;
   localparam int WATCHDOG_CYC = 20000;

   // vector fields: {mode, rw, addr, wdata}
   localparam logic [VW-1:0] VECS [NV] = '{
      {1'b1, 1'b0, 21'h1ABCD, 32'hDEADBEEF},
      {1'b1, 1'b1, 21'h00042, 32'h0},
      {1'b0, 1'b0, 21'h1FFFFF, 32'h12345678},
      {1'b0, 1'b1, 21'h0F0F0, 32'h0},
      {1'b1, 1'b1, 21'h1FFFFF, 32'h0},
      {1'b0, 1'b0, 21'h00000, 32'hFFFFFFFF}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sync_mode = 1'b1;
   logic          bus_cs_n = 1'b1, bus_as_n = 1'b1, bus_rw = 1'b1, bus_ds_n = 1'b1;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata, reg_wdata, reg_rdata;
   logic          bus_ack, reg_rd, reg_wr;
   logic [AW-1:0] reg_addr;

   int checks = 0;
   int fails = 0;
   int n_acc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   assign reg_rdata = {{(DW-AW){1'b0}}, reg_addr} ^ 32'hC3C3_0000;

   function automatic logic [DW-1:0] model_rd(input logic [AW-1:0] a);
      return {{(DW-AW){1'b0}}, a} ^ 32'hC3C3_0000;
   endfunction

   always @(posedge clk) if (reg_rd || reg_wr) n_acc++;

   mpbus_slave dut_i (
      .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
      .bus_cs_n(bus_cs_n), .bus_as_n(bus_as_n), .bus_rw(bus_rw), .bus_ds_n(bus_ds_n),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_sync(input logic rw, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic ds_lvl);
      int base;
      @(negedge clk);
      sync_mode = 1'b1; bus_ds_n = ds_lvl;
      bus_addr = a; bus_rw = rw; bus_wdata = d; bus_as_n = 1'b0; bus_cs_n = 1'b0;
      base = n_acc;
      @(negedge clk);
      chk("R2", "strobe one cycle after edge", {62'd0, reg_rd, reg_wr}, {62'd0, rw, ~rw});
      chk("R3", "address on strobe", 64'(reg_addr), 64'(a));
      if (!rw) chk("R4", "write data on strobe", 64'(reg_wdata), 64'(d));
      bus_as_n = 1'b1; bus_cs_n = 1'b1; bus_addr = ~a;
      @(negedge clk);
      chk("R8", "ack after strobe", 64'(bus_ack), 64'd1);
      chk("R8", "read data", 64'(bus_rdata), rw ? 64'(model_rd(a)) : 64'd0);
      chk("R3", "address held after strobe", 64'(reg_addr), 64'(a));
      @(negedge clk);
      chk("R9", "ack second cycle", 64'(bus_ack), 64'd1);
      @(negedge clk);
      chk("R9", "ack released", {63'd0, bus_ack}, 64'd0);
      chk("R9", "rdata cleared", 64'(bus_rdata), 64'd0);
      chk("R2", "single access", 64'(n_acc - base), 64'd1);
   endtask

   task automatic do_async(input logic rw, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input int extra);
      int base;
      @(negedge clk);
      sync_mode = 1'b0; bus_ds_n = 1'b1;
      bus_addr = a; bus_rw = rw; bus_wdata = d; bus_as_n = 1'b0; bus_cs_n = 1'b0;
      repeat (2) @(negedge clk);
      base = n_acc;
      bus_ds_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6", "no strobe before fourth cycle", 64'(n_acc - base), 64'd0);
      @(negedge clk);
      chk("R6", "strobe in fourth cycle", {62'd0, reg_rd, reg_wr}, {62'd0, rw, ~rw});
      chk("R4", "address on strobe", 64'(reg_addr), 64'(a));
      if (!rw) chk("R4", "write data on strobe", 64'(reg_wdata), 64'(d));
      @(negedge clk);
      chk("R8", "ack after strobe", 64'(bus_ack), 64'd1);
      chk("R8", "read data", 64'(bus_rdata), rw ? 64'(model_rd(a)) : 64'd0);
      repeat (extra) @(negedge clk);
      chk("R6", "one access per strobe low", 64'(n_acc - base), 64'd1);
      chk("R10", "ack held while strobe low", 64'(bus_ack), 64'd1);
      bus_ds_n = 1'b1; bus_as_n = 1'b1; bus_cs_n = 1'b1; bus_addr = ~a;
      repeat (2) @(negedge clk);
      chk("R10", "ack still high two samples after release", 64'(bus_ack), 64'd1);
      @(negedge clk);
      chk("R10", "ack released third edge", {63'd0, bus_ack}, 64'd0);
      chk("R3", "address held after strobe", 64'(reg_addr), 64'(a));
      chk("R6", "total accesses", 64'(n_acc - base), 64'd1);
   endtask

   initial begin
      int base;
      repeat (3) @(negedge clk);
      chk("R12", "ack after reset", {63'd0, bus_ack}, 64'd0);
      chk("R12", "rdata after reset", 64'(bus_rdata), 64'd0);
      chk("R12", "strobes after reset", {62'd0, reg_rd, reg_wr}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // vector table: R1 R2 R4 R8 R9 R6 R10
      for (int i = 0; i < NV; i++) begin
         if (VECS[i][VW-1])
            do_sync(VECS[i][VW-2], VECS[i][DW +: AW], VECS[i][DW-1:0], 1'b1);
         else
            do_async(VECS[i][VW-2], VECS[i][DW +: AW], VECS[i][DW-1:0], 2);
         repeat (2) @(negedge clk);
      end

      // R2: address strobe with chip select high
      sync_mode = 1'b1; base = n_acc;
      bus_as_n = 1'b0; bus_cs_n = 1'b1;
      @(negedge clk); bus_as_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R2", "deselected strobe ignored", 64'(n_acc - base), 64'd0);
      chk("R2", "no ack when deselected", {63'd0, bus_ack}, 64'd0);

      // R5: data strobe toggling in clocked mode
      base = n_acc;
      for (int i = 0; i < 6; i++) begin
         bus_ds_n = ~bus_ds_n;
         @(negedge clk);
      end
      repeat (3) @(negedge clk);
      chk("R5", "data strobe toggles ignored", 64'(n_acc - base), 64'd0);
      do_sync(1'b1, 21'h15555, 32'h0, 1'b0);
      bus_ds_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: clocked-style pulse in strobe-only mode
      sync_mode = 1'b0; base = n_acc;
      bus_addr = 21'h00777; bus_as_n = 1'b0; bus_cs_n = 1'b0;
      @(negedge clk); bus_as_n = 1'b1; bus_cs_n = 1'b1;
      repeat (8) @(negedge clk);
      chk("R1", "pulse without data strobe ignored", 64'(n_acc - base), 64'd0);
      chk("R1", "no ack in strobe-only mode", {63'd0, bus_ack}, 64'd0);

      // R7: data strobe falls while deselected
      base = n_acc;
      bus_as_n = 1'b0; bus_cs_n = 1'b1;
      repeat (2) @(negedge clk);
      bus_ds_n = 1'b0;
      repeat (8) @(negedge clk);
      chk("R7", "no access while deselected", 64'(n_acc - base), 64'd0);
      chk("R7", "no ack while deselected", {63'd0, bus_ack}, 64'd0);
      bus_ds_n = 1'b1; bus_as_n = 1'b1;
      repeat (4) @(negedge clk);

      // R11: data strobe released before issue
      base = n_acc;
      bus_as_n = 1'b0; bus_cs_n = 1'b0; bus_rw = 1'b0; bus_addr = 21'h00ABC;
      repeat (2) @(negedge clk);
      bus_ds_n = 1'b0;
      @(negedge clk); bus_ds_n = 1'b1;
      repeat (8) @(negedge clk);
      chk("R11", "aborted access has no strobe", 64'(n_acc - base), 64'd0);
      chk("R11", "no ack after abort", {63'd0, bus_ack}, 64'd0);
      bus_as_n = 1'b1; bus_cs_n = 1'b1;
      repeat (3) @(negedge clk);
      do_async(1'b1, 21'h00ABC, 32'h0, 0);

      // R6: long data strobe low yields one access
      do_async(1'b0, 21'h1234, 32'hA5A5A5A5, 12);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule